// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address that a synchronous burst memory port presents to its array. An address strobe accepted on a clock edge captures the external address and opens a four-word burst. Each later edge with the advance input low, and no strobe, steps the two least significant address bits to the next word of the burst. The upper bits stay as they were captured.

Two strobes can start a burst, and they are qualified differently. The processor strobe counts only while the master chip enable is active. The controller strobe always counts. An accepted strobe loads the address only when the master enable and both secondary enables (one active high, one active low) are all active. Otherwise it deselects the port, and the burst stops until the next load.

A static order input selects how the low bits move through the burst. High selects interleaved order: the captured low bits XOR a count running 0,1,2,3. Low selects linear order: the captured low bits plus the count, modulo four. After four words the sequence returns to the start word and keeps cycling.

Top module: `burst_addr_seq`

## Requirements
- R1: At reset release `addr_o` is all zeros and `burst_act_o` is 0.
- R2: On an edge where an accepted strobe meets the master enable low, `sel_en_i` high and `sel_en_ni` low, `addr_o` equals the sampled `addr_i` after that edge and `burst_act_o` is 1. This holds through either strobe.
- R3: A low `proc_strb_ni` while `master_en_ni` is high is ignored. Address and burst flag behave exactly as if the strobe were high, so an advance in that cycle still steps the burst.
- R4: A low `ctrl_strb_ni` while `master_en_ni` is high is accepted and deselects. After that edge `burst_act_o` is 0 and `addr_o` keeps its value.
- R5: An accepted strobe with `sel_en_i` low or `sel_en_ni` high deselects without loading. `burst_act_o` drops to 0 and `addr_o` keeps its value.
- R6: During an active burst, an edge with `adv_ni` low and no accepted strobe moves to the next burst word. Bits above bit 1 of `addr_o` do not change.
- R7: With `order_sel_i` = 0 (linear), after k advances the low two bits equal (start + k) mod 4.
- R8: With `order_sel_i` = 1 (interleaved), after k advances the low two bits equal start XOR (k mod 4).
- R9: After the fourth word the next advance returns to the start word, and further advances keep repeating the same four-word sequence.
- R10: An accepted strobe on the same edge as a low `adv_ni` takes priority. The new address is loaded and the burst count restarts at zero.
- R11: An edge with `adv_ni` high and no accepted strobe leaves `addr_o` and `burst_act_o` unchanged.
- R12: While `burst_act_o` is 0, a low `adv_ni` has no effect on `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | External address, sampled when a load occurs |
| proc_strb_ni | input | 1 | Processor address strobe, active low, gated by the master enable |
| ctrl_strb_ni | input | 1 | Controller address strobe, active low, never gated |
| master_en_ni | input | 1 | Master chip enable, active low |
| sel_en_i | input | 1 | Secondary chip enable, active high |
| sel_en_ni | input | 1 | Secondary chip enable, active low |
| adv_ni | input | 1 | Burst advance, active low |
| order_sel_i | input | 1 | Static burst order: 1 interleaved, 0 linear |
| addr_o | output | ADDR_W | Current word address |
| burst_act_o | output | 1 | A burst is loaded and selected |

## Verification
The bench runs both orders from all four start offsets and continues through two full wraps. An adder in place of the XOR, or a sequence that stalls after the fourth word instead of cycling, therefore shows up as a wrong low-bit value.

Other tests put the processor strobe against an inactive master enable with advance low. A design that treats that strobe as a deselect or a reload loses the step that should happen.

Separate tests send the controller strobe with the master enable off and the secondary enables off one at a time. Each of these must drop the burst flag and keep the address, and a later advance must change nothing. A final test sends a strobe together with advance in the middle of a burst. A design that lets advance win, or keeps the old count, lands on a word other than the new start.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bas_strobe_qual.sv
module bas_strobe_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic proc_strb_ni,
  input  logic ctrl_strb_ni,
  input  logic master_en_ni,
  input  logic sel_en_i,
  input  logic sel_en_ni,
  input  logic adv_ni,
  input  logic burst_act_i,
  output logic load_o,
  output logic desel_o,
  output logic step_o
);
  logic proc_take;
  logic strobe_seen;
  logic all_sel;

  always_comb begin
    proc_take   = !proc_strb_ni && !master_en_ni;
    strobe_seen = proc_take || !ctrl_strb_ni;
    all_sel     = !master_en_ni && sel_en_i && !sel_en_ni;
    load_o      = strobe_seen && all_sel;
    desel_o     = strobe_seen && !all_sel;
    step_o      = !strobe_seen && !adv_ni && burst_act_i;
  end

  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_o, desel_o, step_o})); // R10
  AST_STROBE_BEATS_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_strb_ni && !adv_ni) |-> !step_o); // R10
endmodule

// File: rtl/bas_burst_cnt.sv
module bas_burst_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || step_i;
    cnt_d  = cnt_q;
    if (load_i)      cnt_d = '0;
    else if (step_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_o == '0)); // R10
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && (cnt_o == {CNT_W{1'b1}})) |=> (cnt_o == '0)); // R9
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(cnt_o)); // R11
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
  import bas_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  burst_order_e     order_i,
  input  logic [CNT_W-1:0] base_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] lo_o
);
  logic [CNT_W-1:0] lin_lo;
  logic [CNT_W-1:0] ilv_lo;

  assign lin_lo = base_i + cnt_i;

  for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
    assign ilv_lo[b] = base_i[b] ^ cnt_i[b];
  end

  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: lo_o = ilv_lo;
      default:        lo_o = lin_lo;
    endcase
  end

  AST_START_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |-> (lo_o == base_i)); // R9
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_strb_ni,
  input  logic              ctrl_strb_ni,
  input  logic              master_en_ni,
  input  logic              sel_en_i,
  input  logic              sel_en_ni,
  input  logic              adv_ni,
  input  logic              order_sel_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              burst_act_o
);
  localparam int UP_W = ADDR_W - CNT_W;

  logic             rst_meta_q;
  logic             rst_sync_q;
  logic             load;
  logic             desel;
  logic             step;
  logic [UP_W-1:0]  upper_q;
  logic [UP_W-1:0]  upper_d;
  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] base_d;
  logic             act_q;
  logic             act_d;
  logic             act_en;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lo;
  burst_order_e     order;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign order = burst_order_e'(order_sel_i);

  bas_strobe_qual u_qual (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_q),
    .proc_strb_ni (proc_strb_ni),
    .ctrl_strb_ni (ctrl_strb_ni),
    .master_en_ni (master_en_ni),
    .sel_en_i     (sel_en_i),
    .sel_en_ni    (sel_en_ni),
    .adv_ni       (adv_ni),
    .burst_act_i  (act_q),
    .load_o       (load),
    .desel_o      (desel),
    .step_o       (step)
  );

  bas_burst_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .load_i (load),
    .step_i (step),
    .cnt_o  (cnt)
  );

  bas_order_map #(.CNT_W(CNT_W)) u_map (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_q),
    .order_i (order),
    .base_i  (base_q),
    .cnt_i   (cnt),
    .lo_o    (lo)
  );

  always_comb begin
    upper_d = addr_i[ADDR_W-1:CNT_W];
    base_d  = addr_i[CNT_W-1:0];
    act_en  = load || desel;
    act_d   = load;
  end

  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      upper_q <= '0;
      base_q  <= '0;
    end else if (load) begin
      upper_q <= upper_d;
      base_q  <= base_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q)  act_q <= 1'b0;
    else if (act_en)  act_q <= act_d;
  end

  assign addr_o      = {upper_q, lo};
  assign burst_act_o = act_q;

  AST_LOAD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    load |=> (addr_o == $past(addr_i)) && burst_act_o); // R2
  AST_PROC_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (!proc_strb_ni && master_en_ni && ctrl_strb_ni && adv_ni)
      |=> $stable(addr_o) && $stable(burst_act_o)); // R3
  AST_CTRL_DESEL: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (!ctrl_strb_ni && master_en_ni) |=> !burst_act_o && $stable(addr_o)); // R4
  AST_UPPER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !load |=> $stable(addr_o[ADDR_W-1:CNT_W])); // R6
  AST_IDLE_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (!burst_act_o && proc_strb_ni && ctrl_strb_ni) |=> $stable(addr_o)); // R12
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          proc_n, ctrl_n, mst_n, sel_en, sel_n, adv_n, ord;
  logic [AW-1:0] addr_o;
  logic          act_o;
  int            n_chk = 0;
  int            n_err = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_i),
    .proc_strb_ni(proc_n), .ctrl_strb_ni(ctrl_n), .master_en_ni(mst_n),
    .sel_en_i(sel_en), .sel_en_ni(sel_n), .adv_ni(adv_n),
    .order_sel_i(ord), .addr_o(addr_o), .burst_act_o(act_o)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_lo(input logic [1:0] s, input int k, input logic m);
    logic [1:0] kk = 2'(k % 4);
    return m ? (s ^ kk) : 2'(s + kk);
  endfunction

  task automatic idle();
    proc_n = 1; ctrl_n = 1; mst_n = 0; sel_en = 1; sel_n = 0; adv_n = 1;
  endtask

  task automatic tick();
    @(posedge clk); #2;
    idle();
  endtask

  task automatic load(input logic [AW-1:0] a, input bit via_ctrl);
    addr_i = a;
    if (via_ctrl) ctrl_n = 0; else proc_n = 0;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 addr", addr_o, '0);
    chk("R1 act", {17'd0, act_o}, 18'd0);
  endtask

  task automatic t_orders();
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a = {16'(16'h5A3 + s * 16'h111), 2'(s)};
        ord = m[0];
        load(a, s[0]);
        chk("R2 load", addr_o, a);
        chk("R2 act", {17'd0, act_o}, 18'd1);
        for (int k = 1; k <= 8; k++) begin
          adv_n = 0;
          tick();
          chk(m ? "R8 R9 interleaved step" : "R7 R9 linear step", addr_o,
              {a[AW-1:2], exp_lo(2'(s), k, m[0])});
        end
      end
    end
  endtask

  task automatic t_hold();
    load(18'h2_3456, 1'b0);
    adv_n = 0; tick();
    for (int i = 0; i < 3; i++) tick();
    chk("R11 hold", addr_o, {16'h8D15, exp_lo(2'b10, 1, ord)});
    chk("R11 act", {17'd0, act_o}, 18'd1);
  endtask

  task automatic t_proc_blocked();
    ord = 0;
    load(18'h0_1001, 1'b0);
    addr_i = 18'h3_FFFC; mst_n = 1; proc_n = 0; tick();
    chk("R3 no load", addr_o, 18'h0_1001);
    chk("R3 act kept", {17'd0, act_o}, 18'd1);
    addr_i = 18'h3_FFFC; mst_n = 1; proc_n = 0; adv_n = 0; tick();
    chk("R3 advance still steps", addr_o, 18'h0_1002);
  endtask

  task automatic t_ctrl_desel();
    ord = 1;
    load(18'h1_2341, 1'b1);
    addr_i = 18'h0_0002; mst_n = 1; ctrl_n = 0; tick();
    chk("R4 act dropped", {17'd0, act_o}, 18'd0);
    chk("R4 addr kept", addr_o, 18'h1_2341);
    adv_n = 0; tick();
    adv_n = 0; tick();
    chk("R12 no step when idle", addr_o, 18'h1_2341);
  endtask

  task automatic t_sec_en();
    ord = 0;
    load(18'h0_7773, 1'b0);
    addr_i = 18'h1_1110; sel_en = 0; ctrl_n = 0; tick();
    chk("R5 sel_en low deselect", {17'd0, act_o}, 18'd0);
    chk("R5 addr kept", addr_o, 18'h0_7773);
    load(18'h0_4440, 1'b1);
    addr_i = 18'h1_1111; sel_n = 1; proc_n = 0; tick();
    chk("R5 sel_n high deselect", {17'd0, act_o}, 18'd0);
    chk("R5 addr kept 2", addr_o, 18'h0_4440);
  endtask

  task automatic t_strobe_wins();
    ord = 0;
    load(18'h0_0100, 1'b0);
    adv_n = 0; tick();
    adv_n = 0; tick();
    addr_i = 18'h2_2222; ctrl_n = 0; adv_n = 0; tick();
    chk("R10 strobe over advance", addr_o, 18'h2_2222);
    adv_n = 0; tick();
    chk("R10 count restarted", addr_o, 18'h2_2223);
  endtask

  initial begin
    rst_n = 0; addr_i = '0; ord = 1;
    idle();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    t_orders();
    t_hold();
    t_proc_blocked();
    t_ctrl_desel();
    t_sec_en();
    t_strobe_wins();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule